// File: doc/BRIEF.md
# Two-Level Cache Access Controller

This block sequences every processor request through a first-level cache backed by an inclusive second-level cache. It accepts one request at a time, along with the tag lookup results for both levels, whether the hit line is in the Shared coherence state, and the way chosen for replacement. It then drives the control strobes for the data arrays and the system bus. The tag and data arrays sit outside the block. So do snooping and the choice of victim.

A read that misses the first level is first offered to the second level. If the second level hits, the line moves up one beat per cycle. If both levels miss, the block issues a line-aligned burst read on the bus and writes every returned beat into both levels at once. The processor gets its data as soon as the beat holding the requested address arrives. The line is marked valid only when the final beat has been written.

Writes that hit update the cached copies. A write that misses, or that touches a Shared line, also goes out as a single bus write. Two bits of a control word choose the operating mode: a cache-disable bit and a no-write-through bit. With caching disabled, misses allocate nothing and are served by single bus cycles.

Top module: `l2l1_access_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `bus_req`, `cpu_done`, both fill strobes and both validate strobes are 0.
- R2: The cache-disable flag is bit 30 and the no-write-through flag is bit 29 of `ctrl_word`. Both are sampled when a request is accepted. With bit 30 clear, the block runs in normal mode whatever bit 29 and the other bits hold.
- R3: A read that hits the first level completes with `cpu_done` in the cycle after acceptance. It causes no bus cycle and no fill.
- R4: In normal mode, a read that misses the first level but hits the second runs one transfer cycle per beat, four beats by default. In those cycles `l2_to_l1` and `fill_l1` are 1, `fill_l2` is 0, and `fill_beat` counts 0 upward. `cpu_done` is 1 in the transfer cycle whose beat equals address bits [4:3].
- R5: In normal mode, a read that misses both levels raises `bus_req` with `bus_burst`=1, `bus_we`=0 and `bus_addr` aligned to the 32-byte line. Each `bus_ack` writes the beat into both levels, with `fill_beat` counting 0 upward and `fill_data` equal to `bus_rdata`. `cpu_done` and `cpu_rdata`=`bus_rdata` appear on the beat selected by address bits [4:3].
- R6: `l1_set_valid` is asserted only in the cycle of the final beat, for both a transfer and a burst. `l2_set_valid` is asserted only on the final beat of a burst.
- R7: In normal mode, a write that hits an unshared line completes in the cycle after acceptance. It pulses `l1_upd` when the first level hit and `l2_upd` when the second level hit, and it causes no bus cycle.
- R8: A write that misses both levels issues one bus cycle with `bus_we`=1, the full address and the write data. It causes no fill and no update, and completes on `bus_ack`.
- R9: A write that hits a Shared line issues a single bus write. In the `bus_ack` cycle it pulses `cpu_done` together with the update strobes of the levels that hit.
- R10: With cache-disable set, a read that misses the first level issues one non-burst bus read at the full address. It produces no fill and no validate, and returns `bus_rdata` with `cpu_done` on `bus_ack`. Reads that hit the first level are still served as in R3.
- R11: With cache-disable set and no-write-through clear, every write goes to the bus, including unshared hits. With both bits set, an unshared write hit stays off the bus.
- R12: Only one request is outstanding at a time. `req_ready` is 0 from the cycle after acceptance until the request completes, and `req_valid` has no effect while `req_ready` is 0. Each request gives exactly one `cpu_done`.
- R13: During every fill cycle, `fill_way` equals the way supplied with the request. Outside fill cycles, `fill_beat`, `fill_way` and `fill_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_word | input | CTRL_W | Control word holding the mode flags |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Write data |
| req_l1_hit | input | 1 | First-level tag hit |
| req_l2_hit | input | 1 | Second-level tag hit |
| req_shared | input | 1 | Hit line is in the Shared state |
| req_way | input | WAY_W | Way to fill on allocation |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| cpu_done | output | 1 | Request completion pulse |
| cpu_rdata | output | DATA_W | Read data for bus-served reads, valid with cpu_done |
| l1_upd | output | 1 | Write the request data into the first level |
| l2_upd | output | 1 | Write the request data into the second level |
| l2_to_l1 | output | 1 | Line transfer from second to first level active |
| fill_l1 | output | 1 | Write one beat into the first level |
| fill_l2 | output | 1 | Write one beat into the second level |
| fill_beat | output | BEAT_W | Beat index within the line being filled |
| fill_data | output | DATA_W | Beat data on bus fills |
| fill_way | output | WAY_W | Way being filled |
| l1_set_valid | output | 1 | Mark the first-level line valid |
| l2_set_valid | output | 1 | Mark the second-level line valid |
| bus_req | output | 1 | Bus cycle requested |
| bus_burst | output | 1 | Cycle is a line burst read |
| bus_we | output | 1 | Cycle is a write |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_ack | input | 1 | Beat or single transfer complete |
| bus_rdata | input | DATA_W | Bus read data, valid with bus_ack |

## Verification
The bench builds the block with its default parameters: 32-byte lines, 8-byte beats (so four beats), four ways and a 32-bit control word. With only four beats per line, the critical beat can be placed on each position in turn, including the first and last. That brings within reach the cases where completion and validation share a cycle and where they are three beats apart. The bench varies bus latency from zero to two idle cycles between acknowledges, so back-to-back beats and stalled beats both occur within one burst. It also uses every way value in the fills.

// File: rtl/acc_pkg.sv
package acc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HIT,
        ST_XFER,
        ST_BURST,
        ST_SRD,
        ST_SWR
    } acc_state_e;

    typedef struct packed {
        logic write;
        logic l1_hit;
        logic l2_hit;
        logic shared;
        logic cd;
        logic nw;
    } acc_look_t;

    // Pick the service path for a freshly accepted request.
    function automatic acc_state_e acc_pick(acc_look_t lk);
        logic any_hit;
        logic through;
        any_hit = lk.l1_hit | lk.l2_hit;
        through = ~any_hit | lk.shared | (lk.cd & ~lk.nw);
        if (lk.write)
            return through ? ST_SWR : ST_HIT;
        if (lk.l1_hit)
            return ST_HIT;
        if (lk.cd)
            return ST_SRD;
        return lk.l2_hit ? ST_XFER : ST_BURST;
    endfunction

endpackage

// File: rtl/acc_route.sv
module acc_route
    import acc_pkg::*;
#(
    parameter int CTRL_W = 32,
    parameter int CD_POS = 30,
    parameter int NW_POS = 29
) (
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic              req_write,
    input  logic              l1_hit,
    input  logic              l2_hit,
    input  logic              shared,
    output acc_look_t         look,
    output acc_state_e        route
);

    always_comb begin
        look.write  = req_write;
        look.l1_hit = l1_hit;
        look.l2_hit = l2_hit;
        look.shared = shared;
        look.cd     = ctrl_word[CD_POS];
        look.nw     = ctrl_word[NW_POS];
        route       = acc_pick(look);
    end

endmodule

// File: rtl/acc_count.sv
module acc_count #(
    parameter int N = 4,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count,
    output logic         at_last
);

    always_ff @(posedge clk) begin
        if (rst || clr)
            count <= '0;
        else if (inc)
            count <= count + W'(1);
    end

    assign at_last = (count == W'(N - 1));

    // R4
    count_range_chk: assert property (@(posedge clk) disable iff (rst)
        (at_last && inc && !clr) |=> (count == '0));

endmodule

// File: rtl/l2l1_access_ctrl.sv
module l2l1_access_ctrl
    import acc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 64,
    parameter int LINE_BYTES = 32,
    parameter int BEAT_BYTES = 8,
    parameter int WAYS       = 4,
    parameter int CTRL_W     = 32,
    parameter int CD_POS     = 30,
    parameter int NW_POS     = 29,
    localparam int BEATS  = LINE_BYTES / BEAT_BYTES,
    localparam int BEAT_W = $clog2(BEATS),
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int BOFF_W = $clog2(BEAT_BYTES),
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_l1_hit,
    input  logic              req_l2_hit,
    input  logic              req_shared,
    input  logic [WAY_W-1:0]  req_way,
    output logic              req_ready,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              l1_upd,
    output logic              l2_upd,
    output logic              l2_to_l1,
    output logic              fill_l1,
    output logic              fill_l2,
    output logic [BEAT_W-1:0] fill_beat,
    output logic [DATA_W-1:0] fill_data,
    output logic [WAY_W-1:0]  fill_way,
    output logic              l1_set_valid,
    output logic              l2_set_valid,
    output logic              bus_req,
    output logic              bus_burst,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata
);

    acc_state_e        state_q, state_d, route;
    acc_look_t         look, look_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [WAY_W-1:0]  way_q;
    logic [BEAT_W-1:0] beat;
    logic              beat_last;
    logic              accept;
    logic              step;
    logic              on_crit;
    logic [BEAT_W-1:0] crit;
    logic              bus_fill;
    logic              done_int;

    acc_route #(
        .CTRL_W (CTRL_W),
        .CD_POS (CD_POS),
        .NW_POS (NW_POS)
    ) u_route (
        .ctrl_word (ctrl_word),
        .req_write (req_write),
        .l1_hit    (req_l1_hit),
        .l2_hit    (req_l2_hit),
        .shared    (req_shared),
        .look      (look),
        .route     (route)
    );

    assign accept   = (state_q == ST_IDLE) && req_valid;
    assign bus_fill = (state_q == ST_BURST) && bus_ack;
    assign step     = (state_q == ST_XFER) || bus_fill;

    acc_count #(.N(BEATS)) u_beat (
        .clk     (clk),
        .rst     (rst),
        .clr     (accept),
        .inc     (step),
        .count   (beat),
        .at_last (beat_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            look_q  <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            way_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                look_q  <= look;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                way_q   <= req_way;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = route;
            ST_HIT:   state_d = ST_IDLE;
            ST_XFER:  if (beat_last) state_d = ST_IDLE;
            ST_BURST: if (bus_ack && beat_last) state_d = ST_IDLE;
            ST_SRD,
            ST_SWR:   if (bus_ack) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    assign crit    = addr_q[OFF_W-1:BOFF_W];
    assign on_crit = (beat == crit);

    always_comb begin
        done_int     = 1'b0;
        cpu_rdata    = '0;
        l1_upd       = 1'b0;
        l2_upd       = 1'b0;
        l1_set_valid = 1'b0;
        l2_set_valid = 1'b0;
        unique case (state_q)
            ST_HIT: begin
                done_int = 1'b1;
                l1_upd   = look_q.write & look_q.l1_hit;
                l2_upd   = look_q.write & look_q.l2_hit;
            end
            ST_XFER: begin
                done_int     = on_crit;
                l1_set_valid = beat_last;
            end
            ST_BURST: begin
                done_int     = bus_ack & on_crit;
                cpu_rdata    = (bus_ack & on_crit) ? bus_rdata : '0;
                l1_set_valid = bus_ack & beat_last;
                l2_set_valid = bus_ack & beat_last;
            end
            ST_SRD: begin
                done_int  = bus_ack;
                cpu_rdata = bus_ack ? bus_rdata : '0;
            end
            ST_SWR: begin
                done_int = bus_ack;
                l1_upd   = bus_ack & look_q.l1_hit;
                l2_upd   = bus_ack & look_q.l2_hit;
            end
            default: ;
        endcase
    end

    assign cpu_done  = done_int;
    assign req_ready = (state_q == ST_IDLE);
    assign l2_to_l1  = (state_q == ST_XFER);
    assign fill_l1   = step;
    assign fill_l2   = bus_fill;
    assign fill_beat = step ? beat : '0;
    assign fill_way  = step ? way_q : '0;
    assign fill_data = bus_fill ? bus_rdata : '0;

    assign bus_req   = (state_q == ST_BURST) || (state_q == ST_SRD) || (state_q == ST_SWR);
    assign bus_burst = (state_q == ST_BURST);
    assign bus_we    = (state_q == ST_SWR);
    assign bus_wdata = (state_q == ST_SWR) ? wdata_q : '0;

    always_comb begin
        if (state_q == ST_BURST)
            bus_addr = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        else if (bus_req)
            bus_addr = addr_q;
        else
            bus_addr = '0;
    end

    // R12
    one_out_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R12
    done_busy_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_done |-> !req_ready);

    // R5
    bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

    // R6
    valid_last_chk: assert property (@(posedge clk) disable iff (rst)
        (l1_set_valid || l2_set_valid) |-> (fill_l1 && fill_beat == BEAT_W'(BEATS - 1)));

    // R5
    fill_pair_chk: assert property (@(posedge clk) disable iff (rst)
        fill_l2 |-> (fill_l1 && bus_ack && bus_burst));

    // R10
    burst_read_chk: assert property (@(posedge clk) disable iff (rst)
        bus_burst |-> (bus_req && !bus_we));

    // R7
    upd_done_chk: assert property (@(posedge clk) disable iff (rst)
        (l1_upd || l2_upd) |-> cpu_done);

endmodule

// File: tb/tb_l2l1_access_ctrl.sv
module tb_l2l1_access_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ctrl_word = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        req_l1_hit = 1'b0;
    logic        req_l2_hit = 1'b0;
    logic        req_shared = 1'b0;
    logic [1:0]  req_way = '0;
    logic        bus_ack = 1'b0;
    logic [63:0] bus_rdata = '0;

    logic        req_ready, cpu_done, l1_upd, l2_upd, l2_to_l1;
    logic        fill_l1, fill_l2, l1_set_valid, l2_set_valid;
    logic        bus_req, bus_burst, bus_we;
    logic [63:0] cpu_rdata, fill_data, bus_wdata;
    logic [1:0]  fill_beat, fill_way;
    logic [31:0] bus_addr;

    always #5 clk = ~clk;

    l2l1_access_ctrl dut (
        .clk(clk), .rst(rst), .ctrl_word(ctrl_word),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_l1_hit(req_l1_hit), .req_l2_hit(req_l2_hit),
        .req_shared(req_shared), .req_way(req_way),
        .req_ready(req_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .l1_upd(l1_upd), .l2_upd(l2_upd), .l2_to_l1(l2_to_l1),
        .fill_l1(fill_l1), .fill_l2(fill_l2), .fill_beat(fill_beat),
        .fill_data(fill_data), .fill_way(fill_way),
        .l1_set_valid(l1_set_valid), .l2_set_valid(l2_set_valid),
        .bus_req(bus_req), .bus_burst(bus_burst), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    // Reference model: phase 0 idle, 1 local, 2 up-transfer, 3 burst,
    // 4 single read, 5 single write.
    int          ph = 0, beat = 0, gapc = 0, lat = 0, crit = 0;
    logic [31:0] m_addr = '0;
    logic [63:0] m_wdata = '0;
    int          m_way = 0;
    bit          m_w = 0, m_h1 = 0, m_h2 = 0;
    int          n_chk = 0, n_bad = 0, ncyc = 0, ndone = 0, nbus = 0, nfill = 0;
    string       cur_tag = "R1";

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    task automatic chk(string tag, string nm, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, nm, act, exp);
        end
    endtask

    task automatic cyc();
        bit ack, done_e, fill_e;
        int last;
        last = 3;
        ack = (ph >= 3) && (gapc == 0);
        bus_ack   = ack;
        bus_rdata = {m_addr ^ 32'hC0DE_0000, 32'(beat) ^ 32'(ncyc)};
        #2;
        fill_e = (ph == 2) || (ph == 3 && ack);
        done_e = (ph == 1) || (ph == 2 && beat == crit) || (ph == 3 && ack && beat == crit)
                 || ((ph == 4 || ph == 5) && ack);
        chk(cur_tag, "req_ready", 64'(req_ready), 64'(ph == 0));
        chk(cur_tag, "cpu_done", 64'(cpu_done), 64'(done_e));
        chk(cur_tag, "cpu_rdata", cpu_rdata,
            (done_e && (ph == 3 || ph == 4)) ? bus_rdata : 64'h0);
        chk(cur_tag, "l1_upd", 64'(l1_upd),
            64'(m_w && m_h1 && (ph == 1 || (ph == 5 && ack))));
        chk(cur_tag, "l2_upd", 64'(l2_upd),
            64'(m_w && m_h2 && (ph == 1 || (ph == 5 && ack))));
        chk(cur_tag, "l2_to_l1", 64'(l2_to_l1), 64'(ph == 2));
        chk(cur_tag, "fill_l1", 64'(fill_l1), 64'(fill_e));
        chk(cur_tag, "fill_l2", 64'(fill_l2), 64'(ph == 3 && ack));
        chk(cur_tag, "fill_beat", 64'(fill_beat), fill_e ? 64'(beat) : 64'h0);
        chk(cur_tag, "fill_way", 64'(fill_way), fill_e ? 64'(m_way) : 64'h0);
        chk(cur_tag, "fill_data", fill_data, (ph == 3 && ack) ? bus_rdata : 64'h0);
        chk(cur_tag, "l1_set_valid", 64'(l1_set_valid), 64'(fill_e && beat == last));
        chk(cur_tag, "l2_set_valid", 64'(l2_set_valid), 64'(ph == 3 && ack && beat == last));
        chk(cur_tag, "bus_req", 64'(bus_req), 64'(ph >= 3));
        chk(cur_tag, "bus_burst", 64'(bus_burst), 64'(ph == 3));
        chk(cur_tag, "bus_we", 64'(bus_we), 64'(ph == 5));
        chk(cur_tag, "bus_addr", 64'(bus_addr),
            (ph == 3) ? 64'(m_addr & ~32'h1F) : (ph >= 4) ? 64'(m_addr) : 64'h0);
        chk(cur_tag, "bus_wdata", bus_wdata, (ph == 5) ? m_wdata : 64'h0);
        if (cpu_done) ndone++;
        if (bus_req && bus_ack) nbus++;
        if (fill_l1) nfill++;
        @(posedge clk);
        if (rst) ph = 0;
        else begin
            case (ph)
                0: if (req_valid) begin
                    bit cd, nw;
                    cd = ctrl_word[30]; nw = ctrl_word[29];
                    m_w = req_write; m_h1 = req_l1_hit; m_h2 = req_l2_hit;
                    m_addr = req_addr; m_wdata = req_wdata; m_way = int'(req_way);
                    crit = int'(req_addr[4:3]); beat = 0; gapc = lat;
                    if (req_write) begin
                        if (!(req_l1_hit || req_l2_hit)) ph = 5;
                        else if (req_shared) ph = 5;
                        else if (cd && !nw) ph = 5;
                        else ph = 1;
                    end else if (req_l1_hit) ph = 1;
                    else if (cd) ph = 4;
                    else if (req_l2_hit) ph = 2;
                    else ph = 3;
                end
                1: ph = 0;
                2: begin
                    if (beat == 3) begin ph = 0; beat = 0; end
                    else beat++;
                end
                default: begin
                    if (ack) begin
                        gapc = lat;
                        if (ph != 3 || beat == 3) begin ph = 0; beat = 0; end
                        else beat++;
                    end else gapc--;
                end
            endcase
        end
        ncyc++;
        @(negedge clk);
        if (ncyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    endtask

    task automatic issue(bit w, logic [31:0] a, bit h1, bit h2, bit sh, int way,
                         logic [31:0] ctrl, int latency, int hold,
                         int exp_bus, int exp_fill);
        bit acc;
        int d0, b0, f0;
        d0 = ndone; b0 = nbus; f0 = nfill;
        req_write = w; req_addr = a; req_l1_hit = h1; req_l2_hit = h2;
        req_shared = sh; req_way = 2'(way); ctrl_word = ctrl;
        req_wdata = {a, ~a}; lat = latency; req_valid = 1'b1;
        acc = 0;
        while (!acc) begin
            acc = (ph == 0);
            cyc();
        end
        // Disturb every request input; a busy block must ignore all of it.
        req_write = ~w; req_addr = ~a; req_l1_hit = ~h1; req_l2_hit = ~h2;
        req_shared = ~sh; req_way = ~2'(way); ctrl_word = ~ctrl; req_wdata = '1;
        for (int i = 0; i < hold; i++) if (ph != 0) cyc();
        req_valid = 1'b0;
        while (ph != 0) cyc();
        chk(cur_tag, "done_count(R12)", 64'(ndone - d0), 64'd1);
        chk(cur_tag, "bus_cycles", 64'(nbus - b0), 64'(exp_bus));
        chk(cur_tag, "fill_cycles", 64'(nfill - f0), 64'(exp_fill));
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog timeout");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        // R1: reset state at the ports
        chk("R1", "req_ready", 64'(req_ready), 64'd1);
        chk("R1", "bus_req", 64'(bus_req), 64'd0);
        chk("R1", "cpu_done", 64'(cpu_done), 64'd0);
        chk("R1", "fill", 64'({fill_l1, fill_l2, l1_set_valid, l2_set_valid}), 64'd0);
        @(negedge clk);
        cur_tag = "R1";
        repeat (2) cyc();

        // R3: read served by first level
        cur_tag = "R3";
        issue(0, 32'h0000_1008, 1, 1, 0, 1, 32'h0, 0, 0, 0, 0);
        issue(0, 32'h0000_2010, 1, 1, 1, 0, 32'h4000_0000, 0, 0, 0, 0);

        // R4: up-transfer with the critical beat at every position
        cur_tag = "R4";
        for (int k = 0; k < 4; k++)
            issue(0, 32'h0000_3000 + 32'(k * 8), 0, 1, 0, k, 32'h0, 0, 0, 0, 4);

        // R5 / R6: dual-miss bursts, varied latency and critical beat
        cur_tag = "R5";
        issue(0, 32'h0001_0010, 0, 0, 0, 2, 32'h0, 1, 0, 4, 4);
        issue(0, 32'h0001_0020, 0, 0, 0, 3, 32'h0, 0, 0, 4, 4);
        cur_tag = "R6";
        issue(0, 32'h0001_005C, 0, 0, 0, 1, 32'h0, 2, 0, 4, 4);
        issue(0, 32'h0001_0040, 0, 0, 0, 0, 32'h0, 2, 0, 4, 4);

        // R7: unshared write hits in normal mode
        cur_tag = "R7";
        issue(1, 32'h0002_0008, 1, 1, 0, 0, 32'h0, 0, 0, 0, 0);
        issue(1, 32'h0002_0010, 0, 1, 0, 0, 32'h0, 0, 0, 0, 0);

        // R8: write miss goes out as one write, no allocation
        cur_tag = "R8";
        issue(1, 32'h0003_0004, 0, 0, 0, 3, 32'h0, 2, 0, 1, 0);
        issue(1, 32'h0003_0100, 0, 0, 0, 1, 32'h0, 0, 0, 1, 0);

        // R9: write to a Shared line
        cur_tag = "R9";
        issue(1, 32'h0004_0018, 1, 1, 1, 0, 32'h0, 1, 0, 1, 0);
        issue(1, 32'h0004_0028, 0, 1, 1, 0, 32'h0, 0, 0, 1, 0);

        // R2: bit 29 alone and unrelated high bits leave normal mode
        cur_tag = "R2";
        issue(0, 32'h0005_0008, 0, 0, 0, 2, 32'h2000_0000, 0, 0, 4, 4);
        issue(1, 32'h0005_0010, 1, 1, 0, 0, 32'h9FFF_FFFF, 0, 0, 0, 0);
        issue(0, 32'h0005_0018, 0, 1, 0, 1, 32'hBFFF_FFFF & ~32'h2000_0000, 0, 0, 0, 4);

        // R10: cache disabled, read misses use single cycles
        cur_tag = "R10";
        issue(0, 32'h0006_0014, 0, 1, 0, 2, 32'h4000_0000, 1, 0, 1, 0);
        issue(0, 32'h0006_0018, 0, 0, 0, 2, 32'h6000_0000, 0, 0, 1, 0);

        // R11: write-through policy under cache disable
        cur_tag = "R11";
        issue(1, 32'h0007_0008, 1, 1, 0, 0, 32'h4000_0000, 1, 0, 1, 0);
        issue(1, 32'h0007_0010, 1, 1, 0, 0, 32'h6000_0000, 0, 0, 0, 0);
        issue(1, 32'h0007_0018, 0, 0, 0, 0, 32'h6000_0000, 0, 0, 1, 0);

        // R12: requests presented while busy are ignored
        cur_tag = "R12";
        issue(0, 32'h0008_0008, 0, 0, 0, 1, 32'h0, 2, 5, 4, 4);
        issue(1, 32'h0008_0010, 0, 0, 0, 0, 32'h0, 2, 2, 1, 0);

        // R13: fill way follows the request through both fill kinds
        cur_tag = "R13";
        issue(0, 32'h0009_0000, 0, 1, 0, 3, 32'h0, 0, 0, 0, 4);
        issue(0, 32'h0009_0038, 0, 0, 0, 2, 32'h0, 1, 0, 4, 4);

        repeat (3) cyc();
        finish_run();
    end

endmodule